// File: doc/BRIEF.md
# Integer Execute Stage with Overflow Traps

This block is the execute step of a small 32-bit integer pipeline. Each cycle it takes a decoded 5-bit operation code, two register operands, a 16-bit immediate and a 5-bit shift amount. It registers a 32-bit result, a result-valid flag and an overflow-trap flag. It covers the following groups of operations:

- additions and subtractions, with and without an overflow trap
- signed and unsigned set-on-less-than comparisons, each with a register form and an immediate form
- bitwise AND and OR, each with a register form and an immediate form
- logical shifts
- byte extension, signed and unsigned, of a loaded value

Each operation has its own fixed rule for widening the immediate (sign or zero fill). Each also decides for itself whether signed overflow traps. The word "unsigned" in an operation's name does not set either rule. For example, the unsigned add-immediate still sign-fills its constant, and the unsigned compare-immediate also compares against a sign-filled constant.

The downstream writeback logic uses the valid output to decide whether to write the destination. An operation that traps has its valid output dropped in that same registered cycle, so a trapping result is never committed. The exception handler, the register file and memory access sit outside this block.

Top module: `int_exec_stage`

## Requirements
- R1: The op input selects the operation with these codes: 1 add, 2 addu, 3 sub, 4 subu, 5 addi, 6 addiu, 7 slt, 8 sltu, 9 slti, 10 sltiu, 11 and, 12 or, 13 andi, 14 ori, 15 sll, 16 srl, 17 lb, 18 lbu. For codes 1 to 6 the result is the 32-bit wrapped value of rs_val plus or minus the second operand. That operand is rt_val for codes 1 to 4, and the sign-filled imm for codes 5 and 6.
- R2: trap_q is set one cycle after in_valid is high with code 1, 3 or 5, exactly when the exact signed result does not fit in 32 bits. Two addends of opposite sign never overflow; subtraction is judged as the addition of the negated second operand.
- R3: Codes 2, 4 and 6 never set trap_q, whatever the operands.
- R4: Codes 7 (signed) and 8 (unsigned) compare rs_val against rt_val. The result is 1 in bit 0 when rs_val is less than rt_val, 0 otherwise, and bits 31..1 are always zero.
- R5: Codes 9 and 10 compare rs_val against the sign-filled imm. Code 9 compares as signed and code 10 as unsigned.
- R6: Codes 11 and 12 give the bitwise AND and OR of rs_val and rt_val. Codes 13 and 14 give the same operations against the zero-filled imm.
- R7: Code 15 shifts rt_val left and code 16 shifts it right, by shamt (0 to 31) positions, filling the vacated bits with zeros.
- R8: Code 17 places rs_val[7:0] in the low byte and copies bit 7 into bits 31..8. Code 18 places the same byte and fills bits 31..8 with zeros.
- R9: Code 0 and codes 19 to 31 give a zero result and never set trap_q.
- R10: valid_q is high one cycle after in_valid is high, unless that operation sets trap_q; trap_q and valid_q are never high together. When in_valid is low, neither flag is set.
- R11: All three outputs are registers updated on the rising clock edge. A synchronous reset clears them all to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The operation on the inputs is live this cycle |
| op | input | 5 | Operation code |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate constant |
| shamt | input | 5 | Shift amount |
| result_q | output | 32 | Registered result |
| valid_q | output | 1 | Registered write enable for the result |
| trap_q | output | 1 | Registered overflow trap |

## Verification
The hardest case to reach is an immediate whose sign-fill flips an outcome. This happens with overflow on add-immediate, and with an unsigned compare-immediate against a negative constant that becomes a very large unsigned value. These outcomes appear only when operand extremes meet immediates of both signs. The stimulus therefore crosses every op code, including the unlisted ones, with a grid of boundary operands (zero, one, the signed limits, all ones, values with bit 7 or bit 15 set) and with immediates on both sides of the sign boundary. The shift amount rotates through all 32 values, and in_valid is periodically dropped, including on overflowing operations, to show that the trap is gated.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int XLEN    = 32;
    localparam int IMM_W   = 16;
    localparam int OP_W    = 5;
    localparam int SHAMT_W = $clog2(XLEN);
    localparam int BYTE_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 5'd0,
        OP_ADD   = 5'd1,
        OP_ADDU  = 5'd2,
        OP_SUB   = 5'd3,
        OP_SUBU  = 5'd4,
        OP_ADDI  = 5'd5,
        OP_ADDIU = 5'd6,
        OP_SLT   = 5'd7,
        OP_SLTU  = 5'd8,
        OP_SLTI  = 5'd9,
        OP_SLTIU = 5'd10,
        OP_AND   = 5'd11,
        OP_OR    = 5'd12,
        OP_ANDI  = 5'd13,
        OP_ORI   = 5'd14,
        OP_SLL   = 5'd15,
        OP_SRL   = 5'd16,
        OP_LB    = 5'd17,
        OP_LBU   = 5'd18
    } op_e;

    // Where the second operand comes from
    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_SEXT = 2'd1,
        BSRC_ZEXT = 2'd2
    } bsrc_e;

    // Which unit drives the result
    typedef enum logic [2:0] {
        SEL_ZERO = 3'd0,
        SEL_SUM  = 3'd1,
        SEL_LT   = 3'd2,
        SEL_AND  = 3'd3,
        SEL_OR   = 3'd4,
        SEL_SHL  = 3'd5,
        SEL_SHR  = 3'd6,
        SEL_BYTE = 3'd7
    } sel_e;

    typedef struct packed {
        bsrc_e bsrc;
        logic  sub;      // invert second operand, carry in 1
        logic  trap_en;  // signed overflow raises the trap
        logic  sgn;      // signed compare / sign-filled byte
        sel_e  sel;
    } ctrl_t;

    function automatic ctrl_t decode(input logic [OP_W-1:0] code);
        ctrl_t c;
        c = '{bsrc: BSRC_REG, sub: 1'b0, trap_en: 1'b0, sgn: 1'b0, sel: SEL_ZERO};
        case (code)
            OP_ADD:   begin c.sel = SEL_SUM; c.trap_en = 1'b1; end
            OP_ADDU:  begin c.sel = SEL_SUM; end
            OP_SUB:   begin c.sel = SEL_SUM; c.sub = 1'b1; c.trap_en = 1'b1; end
            OP_SUBU:  begin c.sel = SEL_SUM; c.sub = 1'b1; end
            OP_ADDI:  begin c.sel = SEL_SUM; c.bsrc = BSRC_SEXT; c.trap_en = 1'b1; end
            OP_ADDIU: begin c.sel = SEL_SUM; c.bsrc = BSRC_SEXT; end
            OP_SLT:   begin c.sel = SEL_LT; c.sub = 1'b1; c.sgn = 1'b1; end
            OP_SLTU:  begin c.sel = SEL_LT; c.sub = 1'b1; end
            OP_SLTI:  begin c.sel = SEL_LT; c.sub = 1'b1; c.sgn = 1'b1; c.bsrc = BSRC_SEXT; end
            OP_SLTIU: begin c.sel = SEL_LT; c.sub = 1'b1; c.bsrc = BSRC_SEXT; end
            OP_AND:   begin c.sel = SEL_AND; end
            OP_OR:    begin c.sel = SEL_OR; end
            OP_ANDI:  begin c.sel = SEL_AND; c.bsrc = BSRC_ZEXT; end
            OP_ORI:   begin c.sel = SEL_OR; c.bsrc = BSRC_ZEXT; end
            OP_SLL:   begin c.sel = SEL_SHL; end
            OP_SRL:   begin c.sel = SEL_SHR; end
            OP_LB:    begin c.sel = SEL_BYTE; c.sgn = 1'b1; end
            OP_LBU:   begin c.sel = SEL_BYTE; end
            default:  c.sel = SEL_ZERO;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/exec_operand.sv
module exec_operand
    import exec_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0]  reg_val,
    input  logic [IW-1:0] imm,
    input  bsrc_e         bsrc,
    output logic [W-1:0]  opnd
);
    localparam int PAD = W - IW;

    always_comb begin
        case (bsrc)
            BSRC_SEXT: opnd = {{PAD{imm[IW-1]}}, imm};
            BSRC_ZEXT: opnd = {{PAD{1'b0}}, imm};
            default:   opnd = reg_val;
        endcase
    end
endmodule

// File: rtl/exec_addsub.sv
module exec_addsub
    import exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_s,
    output logic         lt_u
);
    logic [W-1:0] b_eff;
    logic         cout;

    assign b_eff       = sub ? ~b : b;
    assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

    // Same-sign addends whose sum changes sign
    assign ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    // Valid when sub is set
    assign lt_s = sum[W-1] ^ ovf;
    assign lt_u = ~cout;
endmodule

// File: rtl/exec_shift.sv
module exec_shift
    import exec_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  logic          right,
    output logic [W-1:0]  out
);
    logic [W-1:0] stage [0:SW];

    assign stage[0] = val;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int DIST = 2 ** i;
        logic [W-1:0] moved;
        assign moved = right ? (stage[i] >> DIST) : (stage[i] << DIST);
        assign stage[i+1] = amt[i] ? moved : stage[i];
    end

    assign out = stage[SW];
endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
    import exec_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W,
    parameter int SW = SHAMT_W,
    parameter int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [W-1:0]      rs_val,
    input  logic [W-1:0]      rt_val,
    input  logic [IW-1:0]     imm,
    input  logic [SW-1:0]     shamt,
    output logic [W-1:0]      result_q,
    output logic              valid_q,
    output logic              trap_q
);
    ctrl_t        ctrl;
    logic [W-1:0] b_opnd;
    logic [W-1:0] sum;
    logic         ovf, lt_s, lt_u;
    logic [W-1:0] shifted;
    logic [W-1:0] res_d;
    logic         trap_d;

    assign ctrl = decode(op);

    exec_operand #(.W(W), .IW(IW)) u_opnd (
        .reg_val (rt_val),
        .imm     (imm),
        .bsrc    (ctrl.bsrc),
        .opnd    (b_opnd)
    );

    exec_addsub #(.W(W)) u_addsub (
        .a    (rs_val),
        .b    (b_opnd),
        .sub  (ctrl.sub),
        .sum  (sum),
        .ovf  (ovf),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    exec_shift #(.W(W), .SW(SW)) u_shift (
        .val   (rt_val),
        .amt   (shamt),
        .right (ctrl.sel == SEL_SHR),
        .out   (shifted)
    );

    always_comb begin
        case (ctrl.sel)
            SEL_SUM:  res_d = sum;
            SEL_LT:   res_d = {{(W-1){1'b0}}, (ctrl.sgn ? lt_s : lt_u)};
            SEL_AND:  res_d = rs_val & b_opnd;
            SEL_OR:   res_d = rs_val | b_opnd;
            SEL_SHL,
            SEL_SHR:  res_d = shifted;
            SEL_BYTE: res_d = {{(W-BW){ctrl.sgn & rs_val[BW-1]}}, rs_val[BW-1:0]};
            default:  res_d = '0;
        endcase
    end

    assign trap_d = in_valid & ctrl.trap_en & ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            valid_q  <= 1'b0;
            trap_q   <= 1'b0;
        end else begin
            result_q <= res_d;
            valid_q  <= in_valid & ~trap_d;
            trap_q   <= trap_d;
        end
    end

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result_q == '0 && !valid_q && !trap_q));

    // R10
    trap_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
        trap_q |-> !valid_q);

    // R10
    idle_no_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!valid_q && !trap_q));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADDU || op == OP_SUBU || op == OP_ADDIU) |=> !trap_q);

    // R2
    mixed_sign_add_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && rs_val[W-1] != rt_val[W-1]) |=> !trap_q);

    // R4
    lt_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SLT || op == OP_SLTU) |=> (result_q[W-1:1] == '0));

    // R9
    unlisted_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE || op > OP_LBU) |=> (result_q == '0 && !trap_q));
endmodule

// File: tb/int_exec_stage_test.sv
`timescale 1ns/1ps
module int_exec_stage_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  op;
    logic [31:0] rs_val, rt_val;
    logic [15:0] imm;
    logic [4:0]  shamt;
    logic [31:0] result_q;
    logic        valid_q, trap_q;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    int_exec_stage uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .shamt(shamt),
        .result_q(result_q), .valid_q(valid_q), .trap_q(trap_q)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s op=%0d a=%h b=%h imm=%h sh=%0d act=%h exp=%h",
                     tag, what, op, rs_val, rt_val, imm, shamt, act, exp);
        end
    endtask

    // Reference model from the requirements
    function automatic void model(input logic [4:0] code, input logic [31:0] a,
                                  input logic [31:0] b, input logic [15:0] k,
                                  input logic [4:0] sh, output logic [31:0] r,
                                  output logic ov, output string tag);
        logic [31:0] sx = {{16{k[15]}}, k};
        logic [31:0] zx = {16'h0000, k};
        longint sa  = longint'($signed(a));
        longint sb  = longint'($signed(b));
        longint ssx = longint'($signed(sx));
        longint ex  = 0;
        r = 32'h0; ov = 1'b0; tag = "R9";
        case (code)
            5'd1:  begin ex = sa + sb;  tag = "R2"; end
            5'd2:  begin ex = sa + sb;  tag = "R3"; end
            5'd3:  begin ex = sa - sb;  tag = "R2"; end
            5'd4:  begin ex = sa - sb;  tag = "R3"; end
            5'd5:  begin ex = sa + ssx; tag = "R2"; end
            5'd6:  begin ex = sa + ssx; tag = "R3"; end
            5'd7:  begin r = {31'h0, ($signed(a) < $signed(b))};  tag = "R4"; end
            5'd8:  begin r = {31'h0, (a < b)};                    tag = "R4"; end
            5'd9:  begin r = {31'h0, ($signed(a) < $signed(sx))}; tag = "R5"; end
            5'd10: begin r = {31'h0, (a < sx)};                   tag = "R5"; end
            5'd11: begin r = a & b;  tag = "R6"; end
            5'd12: begin r = a | b;  tag = "R6"; end
            5'd13: begin r = a & zx; tag = "R6"; end
            5'd14: begin r = a | zx; tag = "R6"; end
            5'd15: begin r = b << sh; tag = "R7"; end
            5'd16: begin r = b >> sh; tag = "R7"; end
            5'd17: begin r = {{24{a[7]}}, a[7:0]}; tag = "R8"; end
            5'd18: begin r = {24'h0, a[7:0]};      tag = "R8"; end
            default: ;
        endcase
        if (code >= 5'd1 && code <= 5'd6) begin
            r = ex[31:0];
            if (code == 5'd1 || code == 5'd3 || code == 5'd5)
                ov = (ex != longint'($signed(r)));
        end
    endfunction

    initial begin
        logic [31:0] avals [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                                   32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5680,
                                   32'h0000_007F, 32'hFFFF_8000};
        logic [31:0] bvals [6] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                                   32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_8000};
        logic [15:0] ivals [4] = '{16'h0005, 16'h8000, 16'hFFFF, 16'h7FFF};
        int n = 0;

        // R11: reset with live inputs keeps everything cleared
        rst = 1'b1; in_valid = 1'b1; op = 5'd1;
        rs_val = 32'h7FFF_FFFF; rt_val = 32'h1; imm = 16'h0; shamt = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "result", result_q, 32'h0);
        chk("R11", "valid", {31'h0, valid_q}, 32'h0);
        chk("R11", "trap", {31'h0, trap_q}, 32'h0);
        rst = 1'b0;

        for (int o = 0; o < 32; o++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    for (int ik = 0; ik < 4; ik++) begin
                        logic [31:0] er;
                        logic        eov;
                        string       tag;
                        op       = 5'(o);
                        rs_val   = avals[ia];
                        rt_val   = bvals[ib];
                        imm      = ivals[ik];
                        shamt    = 5'(n);
                        in_valid = (n % 7) != 3;
                        n++;
                        model(op, rs_val, rt_val, imm, shamt, er, eov, tag);
                        @(posedge clk);
                        @(negedge clk);
                        chk(tag, "result", result_q, er);
                        chk((in_valid && eov) ? "R2" : "R10", "trap",
                            {31'h0, trap_q}, {31'h0, in_valid & eov});
                        chk("R10", "valid", {31'h0, valid_q},
                            {31'h0, in_valid & ~eov});
                        if (o == 1 || o == 5)
                            chk("R1", "sum", result_q, er);
                    end
                end
            end
        end

        // R11: mid-run reset overrides an overflowing operation
        op = 5'd1; rs_val = 32'h7FFF_FFFF; rt_val = 32'h7FFF_FFFF; in_valid = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "result", result_q, 32'h0);
        chk("R11", "trap", {31'h0, trap_q}, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "trap", {31'h0, trap_q}, 32'h1);
        chk("R10", "valid", {31'h0, valid_q}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule